// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block owns the control strobes of an asynchronous DRAM for everything that is not a normal access. Out of reset it holds the row strobe, column strobe and write enable high for the power-up pause. It then runs a fixed burst of CAS-before-RAS refresh cycles back to back. Only after the last cycle of that burst does it raise `ready_o` and start serving the access sequencer.

In normal operation an interval timer adds one owed refresh each time a period elapses, so that every row is covered within the retention time. The owed refreshes are kept in a saturating backlog counter. The access sequencer asks for the strobes with `acc_req_i` and keeps them while `acc_grant_o` is high. While it holds the grant, its own strobe levels pass straight through to the DRAM pins. When the strobes come back free, owed refreshes are issued before any new grant is given. Each refresh drives CAS low first, then RAS low, with W held high the whole time. The address and data pins are not used.

All timing comes from parameters (clock period in ps, row count, retention time, pause length and the strobe minimums in ns). Cycle counts are rounded up when derived, except for the refresh interval, which is rounded down so that refreshes are never late.

Top module: `dram_refresh_sched`

## Requirements
- R1: From reset until the pause of ceil(POWERUP_US/clock) cycles has elapsed, `ras_n_o`, `cas_n_o` and `we_n_o` stay high, and `ready_o` and `acc_grant_o` stay low.
- R2: After the pause, exactly INIT_REFRESHES refresh cycles run with no grant given, even if `acc_req_i` is high. `ready_o` rises on the edge that ends the last of them and then stays high.
- R3: Each refresh cycle is: one start cycle with all strobes high, lasting ceil(tRPC) cycles; then CAS low with RAS high for max(ceil(tCSR), ceil(tWRP) minus the start cycles) cycles; then both low for ceil(tRAS) cycles; then all high for ceil(tRP) cycles. After that the strobes are free for one idle cycle before anything else starts.
- R4: `we_n_o` is high during every refresh cycle, whatever level `acc_we_n_i` has.
- R5: Once ready, one refresh is owed every floor(RETENTION_US*1000/ROWS ns / clock) cycles. With the strobes otherwise free, successive refreshes start exactly that many cycles apart.
- R6: Owed refreshes accumulate while a grant is held, up to BACKLOG_MAX. Further periods are dropped. On release, the backlog is issued back to back.
- R7: When the strobes are free and at least one refresh is owed, a refresh starts ahead of a pending `acc_req_i`.
- R8: With the strobes free, nothing owed and `ready_o` high, a high `acc_req_i` gives `acc_grant_o` on the next cycle. While granted, `ras_n_o`, `cas_n_o` and `we_n_o` equal `acc_ras_n_i`, `acc_cas_n_i` and `acc_we_n_i`.
- R9: A grant is never taken back while `acc_req_i` stays high, however many refreshes become owed meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_req_i | input | 1 | Access sequencer wants the strobes; held high for the whole access |
| acc_ras_n_i | input | 1 | Row strobe level from the access sequencer |
| acc_cas_n_i | input | 1 | Column strobe level from the access sequencer |
| acc_we_n_i | input | 1 | Write enable level from the access sequencer |
| acc_grant_o | output | 1 | Strobes belong to the access sequencer |
| ready_o | output | 1 | Power-up pause and initial refresh burst are complete |
| ras_n_o | output | 1 | DRAM row strobe, active low |
| cas_n_o | output | 1 | DRAM column strobe, active low |
| we_n_o | output | 1 | DRAM write enable, active low |

## Verification
The bench builds the block with an 8 ns clock, a 1 us pause, 32 rows and a 64 us retention time. This gives a 125-cycle pause and a 250-cycle refresh interval. At these values the whole power-up sequence and many refresh periods fit in a few thousand cycles. A grant is held for twelve periods, which drives the backlog well past its saturation limit of eight. The strobe timing keeps its default nanosecond values, so the waveform phases come out at 1, 2, 7 and 4 cycles.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [1:0] {PH_PAUSE, PH_INIT, PH_RUN} phase_e;
  typedef enum logic [2:0] {WV_IDLE, WV_PRE, WV_CSR, WV_LOW, WV_RP} wave_e;
  typedef enum logic [1:0] {OWN_IDLE, OWN_RFSH, OWN_ACC} owner_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // round a ns minimum up to whole clock cycles, never below one
  function automatic int ns_to_cyc(int ns, int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  // per-row spacing, rounded down so refresh is never late
  function automatic int rfsh_interval_cyc(int ret_us, int rows, int clk_ps);
    int c;
    c = ((ret_us * 1000) / rows) * 1000 / clk_ps;
    return (c < 2) ? 2 : c;
  endfunction

  function automatic int pause_cyc(int us, int clk_ps);
    int c;
    c = (us * 1000000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/dram_cbr_wave.sv
module dram_cbr_wave
  import dram_rfsh_pkg::*;
#(
  parameter int N_RPC = 1,
  parameter int N_CSR = 2,
  parameter int N_RAS = 7,
  parameter int N_RP  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);

  localparam int NMAX = imax(imax(N_RPC, N_CSR), imax(N_RAS, N_RP));
  localparam int CW   = $clog2(NMAX + 1);
  localparam int LW   = $clog2(N_RAS + 2);

  wave_e           state_q;
  wave_e           state_nxt;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   last;

  always_comb begin
    last      = '0;
    state_nxt = WV_IDLE;
    unique case (state_q)
      WV_PRE:  begin last = CW'(N_RPC - 1); state_nxt = WV_CSR; end
      WV_CSR:  begin last = CW'(N_CSR - 1); state_nxt = WV_LOW; end
      WV_LOW:  begin last = CW'(N_RAS - 1); state_nxt = WV_RP;  end
      WV_RP:   begin last = CW'(N_RP - 1);  state_nxt = WV_IDLE; end
      default: begin last = '0;             state_nxt = WV_IDLE; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WV_IDLE;
      cnt_q   <= '0;
    end else if (state_q == WV_IDLE) begin
      if (start_i) begin
        state_q <= WV_PRE;
        cnt_q   <= '0;
      end
    end else if (cnt_q == last) begin
      state_q <= state_nxt;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o  = (state_q != WV_IDLE);
  assign done_o  = (state_q == WV_RP) && (cnt_q == last);
  assign ras_n_o = (state_q != WV_LOW);
  assign cas_n_o = !((state_q == WV_CSR) || (state_q == WV_LOW));

  // length of the current RAS-low run, for the width check
  logic [LW-1:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          low_run_q <= '0;
    else if (ras_n_o)                     low_run_q <= '0;
    else if (low_run_q != {LW{1'b1}})     low_run_q <= low_run_q + 1'b1;
  end

  p_cas_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(!cas_n_o))
    else $error("RAS fell without CAS already low");

  p_ras_min_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (low_run_q >= LW'(N_RAS)))
    else $error("RAS low time too short");

  p_start_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o)
    else $error("refresh started while one is running");

endmodule

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer #(
  parameter int INTERVAL    = 1953,
  parameter int BACKLOG_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic take_i,
  output logic owed_o
);

  localparam int TW = $clog2(INTERVAL + 1);
  localparam int BW = $clog2(BACKLOG_MAX + 1);

  logic [TW-1:0] tcnt_q;
  logic [BW-1:0] back_q;
  logic          tick;
  logic [BW:0]   sum;

  assign tick = run_i && (tcnt_q == TW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tcnt_q <= '0;
    else if (!run_i)  tcnt_q <= '0;
    else if (tick)    tcnt_q <= '0;
    else              tcnt_q <= tcnt_q + 1'b1;
  end

  always_comb begin
    sum = {1'b0, back_q} + (BW+1)'(tick) - (BW+1)'(take_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              back_q <= '0;
    else if (!run_i)                          back_q <= '0;
    else if (sum > (BW+1)'(BACKLOG_MAX))      back_q <= BW'(BACKLOG_MAX);
    else                                      back_q <= sum[BW-1:0];
  end

  assign owed_o = (back_q != '0);

  p_backlog_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    back_q <= BW'(BACKLOG_MAX))
    else $error("backlog above limit");

  p_backlog_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick && !take_i && back_q < BW'(BACKLOG_MAX)) |=> (back_q == $past(back_q) + 1'b1))
    else $error("elapsed interval not recorded");

  p_take_owed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> owed_o)
    else $error("refresh taken with empty backlog");

endmodule

// File: rtl/dram_rfsh_init.sv
module dram_rfsh_init
  import dram_rfsh_pkg::*;
#(
  parameter int PWR_CYC = 25000,
  parameter int INIT_N  = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rfsh_done_i,
  output phase_e phase_o
);

  localparam int PW = $clog2(PWR_CYC + 1);
  localparam int IW = $clog2(INIT_N + 1);

  logic [PW-1:0] pcnt_q;
  logic [IW-1:0] icnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= PH_PAUSE;
      pcnt_q  <= '0;
      icnt_q  <= '0;
    end else begin
      unique case (phase_o)
        PH_PAUSE: begin
          if (pcnt_q == PW'(PWR_CYC - 1)) phase_o <= PH_INIT;
          else                            pcnt_q  <= pcnt_q + 1'b1;
        end
        PH_INIT: begin
          if (rfsh_done_i) begin
            if (icnt_q == IW'(INIT_N - 1)) phase_o <= PH_RUN;
            icnt_q <= icnt_q + 1'b1;
          end
        end
        PH_RUN:  phase_o <= PH_RUN;
        default: phase_o <= PH_PAUSE;
      endcase
    end
  end

  p_ready_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_RUN) |=> (phase_o == PH_RUN))
    else $error("ready dropped");

  p_ready_after_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_RUN && $past(phase_o) == PH_INIT) |-> $past(rfsh_done_i))
    else $error("ready without a completed refresh");

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_PS         = 8000,
  parameter int ROWS           = 4096,
  parameter int RETENTION_US   = 64000,
  parameter int POWERUP_US     = 200,
  parameter int INIT_REFRESHES = 8,
  parameter int BACKLOG_MAX    = 8,
  parameter int T_RPC_NS       = 3,
  parameter int T_CSR_NS       = 10,
  parameter int T_WRP_NS       = 15,
  parameter int T_RAS_NS       = 50,
  parameter int T_RP_NS        = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_req_i,
  input  logic acc_ras_n_i,
  input  logic acc_cas_n_i,
  input  logic acc_we_n_i,
  output logic acc_grant_o,
  output logic ready_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);

  localparam int N_RPC    = ns_to_cyc(T_RPC_NS, CLK_PS);
  // W goes high when ownership starts, so the lead-in must also cover tWRP
  localparam int N_CSR    = imax(ns_to_cyc(T_CSR_NS, CLK_PS),
                                 ns_to_cyc(T_WRP_NS, CLK_PS) - N_RPC);
  localparam int N_RAS    = ns_to_cyc(T_RAS_NS, CLK_PS);
  localparam int N_RP     = ns_to_cyc(T_RP_NS, CLK_PS);
  localparam int INTERVAL = rfsh_interval_cyc(RETENTION_US, ROWS, CLK_PS);
  localparam int PWR_CYC  = pause_cyc(POWERUP_US, CLK_PS);

  phase_e phase;
  owner_e own_q;
  logic   owed;
  logic   start;
  logic   w_busy;
  logic   w_done;
  logic   w_ras_n;
  logic   w_cas_n;

  assign start = (own_q == OWN_IDLE) &&
                 ((phase == PH_INIT) || ((phase == PH_RUN) && owed));

  dram_rfsh_init #(
    .PWR_CYC (PWR_CYC),
    .INIT_N  (INIT_REFRESHES)
  ) u_init (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rfsh_done_i (w_done),
    .phase_o     (phase)
  );

  dram_rfsh_timer #(
    .INTERVAL    (INTERVAL),
    .BACKLOG_MAX (BACKLOG_MAX)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (phase == PH_RUN),
    .take_i (start && (phase == PH_RUN)),
    .owed_o (owed)
  );

  dram_cbr_wave #(
    .N_RPC (N_RPC),
    .N_CSR (N_CSR),
    .N_RAS (N_RAS),
    .N_RP  (N_RP)
  ) u_wave (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (w_busy),
    .done_o  (w_done),
    .ras_n_o (w_ras_n),
    .cas_n_o (w_cas_n)
  );

  // strobe ownership: refresh wins whenever the strobes are free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= OWN_IDLE;
    end else begin
      unique case (own_q)
        OWN_IDLE: begin
          if (start)                               own_q <= OWN_RFSH;
          else if (phase == PH_RUN && acc_req_i)   own_q <= OWN_ACC;
        end
        OWN_RFSH: if (w_done)     own_q <= OWN_IDLE;
        OWN_ACC:  if (!acc_req_i) own_q <= OWN_IDLE;
        default:                  own_q <= OWN_IDLE;
      endcase
    end
  end

  assign acc_grant_o = (own_q == OWN_ACC);
  assign ready_o     = (phase == PH_RUN);

  always_comb begin
    if (own_q == OWN_ACC) begin
      ras_n_o = acc_ras_n_i;
      cas_n_o = acc_cas_n_i;
      we_n_o  = acc_we_n_i;
    end else begin
      ras_n_o = w_ras_n;
      cas_n_o = w_cas_n;
      we_n_o  = 1'b1;
    end
  end

  p_pause_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_PAUSE) |-> (ras_n_o && cas_n_o && we_n_o && !acc_grant_o))
    else $error("strobes active during pause");

  p_no_grant_early_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !acc_grant_o)
    else $error("grant before ready");

  p_we_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_busy && !acc_grant_o) |-> we_n_o)
    else $error("W low during refresh");

  p_rfsh_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q == OWN_IDLE && ready_o && owed && acc_req_i) |=> !acc_grant_o)
    else $error("grant given while refresh owed");

  p_hold_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_grant_o && acc_req_i) |=> acc_grant_o)
    else $error("grant revoked under request");

  p_grant_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_grant_o |-> !w_busy)
    else $error("grant overlaps refresh");

endmodule

// File: tb/dram_refresh_sched_test.sv
`timescale 1ns/1ps
module dram_refresh_sched_test;

  // bench build: 8 ns clock, 1 us pause, 32 rows / 64 us
  localparam int CLK_PS  = 8000;
  localparam int PWR     = (1 * 1000000 + CLK_PS - 1) / CLK_PS;   // 125
  localparam int INT     = ((64 * 1000) / 32) * 1000 / CLK_PS;    // 250
  localparam int A_RPC   = (3 * 1000 + CLK_PS - 1) / CLK_PS;      // 1
  localparam int A_CSR0  = (10 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int A_WRP   = (15 * 1000 + CLK_PS - 1) / CLK_PS - A_RPC;
  localparam int A_CSR   = (A_CSR0 > A_WRP) ? A_CSR0 : A_WRP;     // 2
  localparam int A_RAS   = (50 * 1000 + CLK_PS - 1) / CLK_PS;     // 7
  localparam int A_RP    = (30 * 1000 + CLK_PS - 1) / CLK_PS;     // 4
  localparam int TOTAL   = A_RPC + A_CSR + A_RAS + A_RP;
  localparam int INIT_N  = 8;
  localparam int MAXB    = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_req, acc_ras, acc_cas, acc_we;
  logic gnt, ready, ras_n, cas_n, we_n;

  always #4 clk = ~clk;

  dram_refresh_sched #(
    .CLK_PS         (CLK_PS),
    .ROWS           (32),
    .RETENTION_US   (64),
    .POWERUP_US     (1),
    .INIT_REFRESHES (INIT_N),
    .BACKLOG_MAX    (MAXB)
  ) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .acc_req_i   (acc_req),
    .acc_ras_n_i (acc_ras),
    .acc_cas_n_i (acc_cas),
    .acc_we_n_i  (acc_we),
    .acc_grant_o (gnt),
    .ready_o     (ready),
    .ras_n_o     (ras_n),
    .cas_n_o     (cas_n),
    .we_n_o      (we_n)
  );

  int vectors = 0;
  int errors  = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: phase 0 pause, 1 init, 2 run; owner 0 free, 1 refresh, 2 access
  int m_phase, m_pcnt, m_icnt, m_own, m_age, m_tcnt, m_back;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_pcnt = 0; m_icnt = 0; m_own = 0;
      m_age = 0; m_tcnt = 0; m_back = 0;
    end else begin
      bit st, dn, tk;
      int nb, nown, nage, nph, ntc;
      st = (m_own == 0) && (m_phase == 1 || (m_phase == 2 && m_back > 0));
      dn = (m_own == 1) && (m_age == TOTAL - 1);
      tk = (m_phase == 2) && (m_tcnt == INT - 1);
      nb = m_back;
      if (m_phase == 2) begin
        nb = m_back + (tk ? 1 : 0) - (st ? 1 : 0);
        if (nb > MAXB) nb = MAXB;
      end
      ntc = (m_phase == 2) ? (tk ? 0 : m_tcnt + 1) : 0;
      nown = m_own;
      if (m_own == 0) begin
        if (st) nown = 1;
        else if (m_phase == 2 && acc_req) nown = 2;
      end else if (m_own == 1) begin
        if (dn) nown = 0;
      end else if (!acc_req) nown = 0;
      nage = st ? 0 : ((m_own == 1) ? m_age + 1 : 0);
      nph = m_phase;
      if (m_phase == 0) begin
        if (m_pcnt == PWR - 1) nph = 1; else m_pcnt++;
      end else if (m_phase == 1 && dn) begin
        if (m_icnt == INIT_N - 1) nph = 2;
        m_icnt++;
      end
      m_phase = nph; m_own = nown; m_age = nage; m_tcnt = ntc; m_back = nb;
    end
  end

  int cyc = 0;
  int fall_cnt = 0;
  int last_fall = 0;
  int bad_we = 0;
  logic prev_ras = 1'b1;

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int e_ras, e_cas, e_we;
      string lreq;
      cyc++;
      if (m_own == 2) begin
        e_ras = acc_ras; e_cas = acc_cas; e_we = acc_we; lreq = "R8";
      end else if (m_own == 1) begin
        e_cas = (m_age >= A_RPC && m_age < A_RPC + A_CSR + A_RAS) ? 0 : 1;
        e_ras = (m_age >= A_RPC + A_CSR && m_age < A_RPC + A_CSR + A_RAS) ? 0 : 1;
        e_we  = 1; lreq = "R3";
      end else begin
        e_ras = 1; e_cas = 1; e_we = 1; lreq = "R3";
      end
      chk(lreq, "ras_n", int'(ras_n), e_ras);
      chk(lreq, "cas_n", int'(cas_n), e_cas);
      chk((m_own == 1) ? "R4" : lreq, "we_n", int'(we_n), e_we);
      chk("R8", "grant", int'(gnt), (m_own == 2) ? 1 : 0);
      chk("R2", "ready", int'(ready), (m_phase == 2) ? 1 : 0);
      if (!gnt && !ras_n && !we_n) bad_we++;
      if (prev_ras && !ras_n) begin
        fall_cnt++;
        last_fall = cyc;
      end
      prev_ras = ras_n;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    vectors++;
    errors++;
    $display("FAIL R2 watchdog: actual %0d cycles expected fewer than %0d", cyc, 200000);
    summary();
  end

  initial begin
    int f0, t0, n;
    rst_n = 1'b0;
    acc_req = 1'b1; acc_ras = 1'b1; acc_cas = 1'b1; acc_we = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    // R1: reset state
    chk("R1", "ras_n after reset", int'(ras_n), 1);
    chk("R1", "cas_n after reset", int'(cas_n), 1);
    chk("R1", "we_n after reset", int'(we_n), 1);
    chk("R1", "ready after reset", int'(ready), 0);
    repeat (PWR - 3) step();
    chk("R1", "RAS falls in pause", fall_cnt, 0);
    chk("R1", "grant in pause", int'(gnt), 0);

    // R2: init burst, request ignored throughout
    n = 0;
    while (!ready && n < 2000) begin step(); n++; end
    chk("R2", "init refresh count", fall_cnt, INIT_N);
    chk("R2", "grant at ready", int'(gnt), 0);
    step();
    chk("R8", "grant after ready", int'(gnt), 1);

    // R9: hold the grant across many intervals
    f0 = fall_cnt;
    repeat (12 * INT) begin
      step();
      acc_cas = ~acc_cas;
    end
    chk("R9", "refresh during grant", fall_cnt - f0, 0);
    chk("R9", "grant kept", int'(gnt), 1);

    // R6 / R7: release one cycle, re-request; backlog drains first
    acc_cas = 1'b1;
    acc_req = 1'b0;
    step();
    acc_req = 1'b1;
    f0 = fall_cnt;
    n = 0;
    while (!gnt && n < 400) begin step(); n++; end
    chk("R7", "refresh ahead of request", (fall_cnt - f0 > 0) ? 1 : 0, 1);
    chk("R6", "saturated backlog drained",
        (fall_cnt - f0 >= MAXB && fall_cnt - f0 <= MAXB + 1) ? 1 : 0, 1);

    // R5: steady spacing with the strobes free
    acc_req = 1'b0;
    f0 = fall_cnt;
    n = 0;
    while (fall_cnt == f0 && n < 2 * INT) begin step(); n++; end
    for (int k = 0; k < 3; k++) begin
      t0 = last_fall;
      f0 = fall_cnt;
      n = 0;
      while (fall_cnt == f0 && n < 2 * INT) begin step(); n++; end
      chk("R5", "refresh spacing", last_fall - t0, INT);
    end

    // R8: request during a refresh is granted once it ends; pass-through
    acc_req = 1'b1;
    n = 0;
    while (!gnt && n < TOTAL + 2) begin step(); n++; end
    chk("R8", "grant after refresh", int'(gnt), 1);
    for (int k = 0; k < 6; k++) begin
      acc_ras = k[0]; acc_cas = k[1]; acc_we = ~k[0];
      step();
      chk("R8", "ras pass-through", int'(ras_n), int'(acc_ras));
    end
    acc_req = 1'b0; acc_ras = 1'b1; acc_cas = 1'b1; acc_we = 1'b0;
    repeat (20) step();
    chk("R4", "W low while refresh owns strobes", bad_we, 0);
    summary();
  end

endmodule